// File: doc/BRIEF.md
# Clock Source and Low-Power Policy Controller

This block selects the system clock source and applies low-power policy for a small microcontroller. Software writes two registers through a simple write port. The policy register holds the clock-source choice and a set of per-function wait-mode rules. The PLL control register holds the PLL power enable, the automatic/manual bandwidth choice, the manual acquisition bit and the lock interrupt enable. A third write address clears the sticky lock-change flag.

A mode request input picks run, wait or stop. From that request and the registers, the block drives several outputs: the clock mux select, the gate enables for the system and core clocks, PLL power-down, oscillator enable and reduced-amplitude control, and run enables and one-cycle clear pulses for the real-time-interrupt and watchdog dividers. The PLL lock input is synchronized, and every change of it is recorded in a sticky flag that can raise an interrupt. The analog PLL, the oscillator and the glitch-free switch cells sit outside the block; here they are only select, enable and lock wires.

Top module: `clk_policy_ctrl`

## Requirements
- R1: After reset the policy register reads 0x00, the PLL control register reads 4'b1100 (PLL on, automatic mode), the oscillator is selected, both clock gates are enabled, the PLL is powered and the lock flag and interrupt are low.
- R2: A write with wr_addr=0 loads the policy register on the next edge. Bit 7 drives sel_pll (1 = PLL clock, 0 = oscillator clock). A write with wr_addr=1 loads the PLL control register from wr_data[3:0] as {pll_on, auto, acq, lock_ie}.
- R3: While the automatic bit is 1 and the synchronized lock is 0, a write to policy bit 7 is ignored and the bit keeps its value. The other bits still load. With lock present, or in manual mode, bit 7 loads normally.
- R4: When a wait request is accepted and policy bit 3 (PLL stop in wait) is 1, bit 7 is cleared at the edge that enters wait. pll_pd stays high for the whole wait, while the PLL-on bit stays 1. On wake, bit 7 is not restored.
- R5: In the cycle a wait request is accepted (mode_req becomes 2'b01 from another mode), rti_clr pulses for exactly that one cycle if bit 1 is set, and cop_clr does the same if bit 0 is set. During wait, rti_en and cop_en are low under the same bits.
- R6: During wait, sys_clk_en is low if bit 5 is set. core_clk_en is low if bit 2 or bit 5 is set. Both gates return high in the cycle after mode_req leaves 2'b01.
- R7: In stop (mode_req=2'b10), both gates are low and the PLL is powered down. osc_en and osc_low_amp are both equal to bit 6 (pseudo-stop). During wait, osc_low_amp equals bit 4.
- R8: pll_lock_in passes through two flops, so lock_stat follows it two edges later. Any rising or falling change sets lock_flag one edge after that.
- R9: Writing wr_addr=2 with wr_data[0]=1 clears lock_flag. A 0 in that bit leaves the flag unchanged. lock_irq is high exactly when lock_flag and lock_ie are both 1.
- R10: filt_acq is the inverse of lock_stat in automatic mode and equals the acq bit in manual mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 policy, 1 PLL control, 2 flag clear |
| wr_data | input | 8 | Write data |
| mode_req | input | 2 | 00 run, 01 wait, 10 stop |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| ctrl_q | output | 8 | Policy register contents |
| pllctl_q | output | 4 | PLL control register {pll_on, auto, acq, lock_ie} |
| sel_pll | output | 1 | Clock mux select, 1 = PLL |
| sys_clk_en | output | 1 | System clock gate enable |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_pd | output | 1 | PLL power-down |
| osc_en | output | 1 | Oscillator enable |
| osc_low_amp | output | 1 | Oscillator reduced amplitude |
| filt_acq | output | 1 | Loop filter in acquisition mode |
| rti_en | output | 1 | RTI divider run enable |
| cop_en | output | 1 | Watchdog divider run enable |
| rti_clr | output | 1 | RTI divider clear pulse |
| cop_clr | output | 1 | Watchdog divider clear pulse |
| lock_stat | output | 1 | Synchronized lock |
| lock_flag | output | 1 | Sticky lock-change flag |
| lock_irq | output | 1 | Lock interrupt request |

## Verification
Two functions can act in the same cycle. The first is the hardware clearing of the PLL-select bit on wait entry. The second is a software write to the policy register, or a lock change that sets the flag while software writes a flag clear. The bench makes each happen by issuing the register write in the same cycle as the wait request, or by timing the clear write to land on the edge where the flag sets. It then judges the result by the rules: the hardware clear wins for bit 7, and a flag set wins over a clear.

// File: rtl/clk_policy_ctrl.sv
module clk_policy_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] mode_req,
  input  logic       pll_lock_in,
  output logic [7:0] ctrl_q,
  output logic [3:0] pllctl_q,
  output logic       sel_pll,
  output logic       sys_clk_en,
  output logic       core_clk_en,
  output logic       pll_pd,
  output logic       osc_en,
  output logic       osc_low_amp,
  output logic       filt_acq,
  output logic       rti_en,
  output logic       cop_en,
  output logic       rti_clr,
  output logic       cop_clr,
  output logic       lock_stat,
  output logic       lock_flag,
  output logic       lock_irq
);
  localparam logic [1:0] MODE_WAIT = 2'b01;
  localparam logic [1:0] MODE_STOP = 2'b10;

  logic [7:0] pol;
  logic [3:0] pctl;
  logic [2:0] lk;
  logic       in_wait, in_stop, flag;

  wire wr_pol   = wr_en && (wr_addr == 2'd0);
  wire wr_pctl  = wr_en && (wr_addr == 2'd1);
  wire wr_flag  = wr_en && (wr_addr == 2'd2);
  wire wait_req = (mode_req == MODE_WAIT);
  wire stop_req = (mode_req == MODE_STOP);
  wire wait_acc = wait_req && !in_wait;
  wire lock_s   = lk[1];
  wire lock_chg = lk[1] ^ lk[2];
  wire sel_hold = pctl[2] && !lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol  <= 8'h00;
      pctl <= 4'b1100;
    end else begin
      if (wr_pol)
        pol <= {sel_hold ? pol[7] : wr_data[7], wr_data[6:0]};
      if (wait_acc && pol[3])
        pol[7] <= 1'b0;
      if (wr_pctl)
        pctl <= wr_data[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_wait <= 1'b0;
      in_stop <= 1'b0;
      lk      <= 3'b000;
      flag    <= 1'b0;
    end else begin
      in_wait <= wait_req;
      in_stop <= stop_req;
      lk      <= {lk[1:0], pll_lock_in};
      if (lock_chg)
        flag <= 1'b1;
      else if (wr_flag && wr_data[0])
        flag <= 1'b0;
    end
  end

  assign ctrl_q      = pol;
  assign pllctl_q    = pctl;
  assign sel_pll     = pol[7];
  assign sys_clk_en  = !in_stop && !(in_wait && pol[5]);
  assign core_clk_en = !in_stop && !(in_wait && (pol[5] || pol[2]));
  assign pll_pd      = !pctl[3] || in_stop || (in_wait && pol[3]);
  assign osc_en      = !in_stop || pol[6];
  assign osc_low_amp = (in_stop && pol[6]) || (in_wait && pol[4]);
  assign filt_acq    = pctl[2] ? !lock_s : pctl[1];
  assign rti_en      = !in_stop && !(in_wait && pol[1]);
  assign cop_en      = !in_stop && !(in_wait && pol[0]);
  assign rti_clr     = wait_acc && pol[1];
  assign cop_clr     = wait_acc && pol[0];
  assign lock_stat   = lock_s;
  assign lock_flag   = flag;
  assign lock_irq    = flag && pctl[0];
endmodule

// File: rtl/clk_policy_ctrl_chk.sv
module clk_policy_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] mode_req,
  input logic [7:0] ctrl_q,
  input logic [3:0] pllctl_q,
  input logic       sys_clk_en,
  input logic       core_clk_en,
  input logic       rti_clr,
  input logic       cop_clr,
  input logic       lock_stat,
  input logic       lock_flag,
  input logic       lock_irq
);
  logic prev_wait, prev_stop;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wait <= 1'b0;
      prev_stop <= 1'b0;
    end else begin
      prev_wait <= (mode_req == 2'b01);
      prev_stop <= (mode_req == 2'b10);
    end
  end
  wire acc = (mode_req == 2'b01) && !prev_wait;

  // R5
  rti_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rti_clr |=> !rti_clr);
  // R5
  cop_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_clr |=> !cop_clr);
  // R4
  sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctrl_q[3]) |=> !ctrl_q[7]);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && pllctl_q[2] && !lock_stat && !ctrl_q[7]) |=> !ctrl_q[7]);
  // R7
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_stop |-> (!sys_clk_en && !core_clk_en));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_flag && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> lock_flag);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_irq |-> (lock_flag && pllctl_q[0]));
endmodule

bind clk_policy_ctrl clk_policy_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode_req(mode_req), .ctrl_q(ctrl_q), .pllctl_q(pllctl_q),
  .sys_clk_en(sys_clk_en), .core_clk_en(core_clk_en), .rti_clr(rti_clr),
  .cop_clr(cop_clr), .lock_stat(lock_stat), .lock_flag(lock_flag), .lock_irq(lock_irq)
);

// File: tb/tb_clk_policy_ctrl.sv
module tb_clk_policy_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, pll_lock_in = 0;
  logic [1:0] wr_addr = 0, mode_req = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_q;
  logic [3:0] pllctl_q;
  logic sel_pll, sys_clk_en, core_clk_en, pll_pd, osc_en, osc_low_amp, filt_acq;
  logic rti_en, cop_en, rti_clr, cop_clr, lock_stat, lock_flag, lock_irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  clk_policy_ctrl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 policy", ctrl_q, 8'h00);
    chk("R1 pllctl", {4'h0, pllctl_q}, 8'h0C);
    chk("R1 outs", {sel_pll, sys_clk_en, core_clk_en, pll_pd, lock_flag, lock_irq, osc_en, 1'b0},
        8'b0110_0010);
  endtask

  task automatic t_auto_block;
    wr(2'd0, 8'h81);
    chk("R3 sel ignored unlocked", ctrl_q, 8'h01);
    chk("R10 auto acq unlocked", {7'd0, filt_acq}, 8'd1);
    pll_lock_in = 1;
    cyc(2);
    chk("R8 lock sync", {7'd0, lock_stat}, 8'd1);
    chk("R10 auto track locked", {7'd0, filt_acq}, 8'd0);
    cyc();
    chk("R8 rise flag", {7'd0, lock_flag}, 8'd1);
    wr(2'd0, 8'h80);
    chk("R2 sel load locked", ctrl_q, 8'h80);
    chk("R2 sel_pll", {7'd0, sel_pll}, 8'd1);
  endtask

  task automatic t_flag;
    wr(2'd2, 8'h00);
    chk("R9 zero write keeps", {7'd0, lock_flag}, 8'd1);
    chk("R9 irq masked", {7'd0, lock_irq}, 8'd0);
    wr(2'd1, 8'h0D);
    chk("R2 pllctl load", {4'h0, pllctl_q}, 8'h0D);
    chk("R9 irq", {7'd0, lock_irq}, 8'd1);
    wr(2'd2, 8'h01);
    chk("R9 clear", {lock_flag, lock_irq}, 8'd0);
    pll_lock_in = 0;
    cyc(2);
    // clear write lands on the edge where the flag sets: set wins
    wr(2'd2, 8'h01);
    chk("R8 fall flag beats clear", {7'd0, lock_flag}, 8'd1);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h0A);
    chk("R10 manual acq", {7'd0, filt_acq}, 8'd1);
    wr(2'd1, 8'h08);
    chk("R10 manual track", {7'd0, filt_acq}, 8'd0);
  endtask

  task automatic t_wait_full;
    wr(2'd0, 8'hAF);
    chk("R2 manual sel", ctrl_q, 8'hAF);
    mode_req = 2'b01;
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'hAF;
    #1;
    chk("R5 clr pulses", {6'd0, rti_clr, cop_clr}, 8'd3);
    chk("R6 gates before entry", {6'd0, sys_clk_en, core_clk_en}, 8'd3);
    cyc();
    wr_en = 0;
    chk("R4 sel cleared over write", ctrl_q, 8'h2F);
    chk("R4 pll down on kept", {6'd0, pll_pd, pllctl_q[3]}, 8'd3);
    chk("R5 pulse one cycle", {6'd0, rti_clr, cop_clr}, 8'd0);
    chk("R5 run enables off", {6'd0, rti_en, cop_en}, 8'd0);
    chk("R6 gates off", {6'd0, sys_clk_en, core_clk_en}, 8'd0);
    cyc(3);
    chk("R5 no repeat pulse", {6'd0, rti_clr, cop_clr}, 8'd0);
    mode_req = 2'b00;
    #1;
    chk("R6 gates still off", {6'd0, sys_clk_en, core_clk_en}, 8'd0);
    cyc();
    chk("R6 gates back", {6'd0, sys_clk_en, core_clk_en}, 8'd3);
    chk("R4 no restore", {7'd0, sel_pll}, 8'd0);
    chk("R4 pll up", {7'd0, pll_pd}, 8'd0);
  endtask

  task automatic t_wait_partial;
    wr(2'd0, 8'h14);
    mode_req = 2'b01;
    #1;
    chk("R5 no pulse bits clear", {6'd0, rti_clr, cop_clr}, 8'd0);
    cyc();
    chk("R6 core only", {6'd0, sys_clk_en, core_clk_en}, 8'd2);
    chk("R7 wait low amp", {6'd0, osc_en, osc_low_amp}, 8'd3);
    chk("R5 enables kept", {6'd0, rti_en, cop_en}, 8'd3);
    mode_req = 2'b00;
    cyc();
  endtask

  task automatic t_stop;
    wr(2'd0, 8'h40);
    mode_req = 2'b10;
    cyc();
    chk("R7 pseudo stop", {4'd0, sys_clk_en, core_clk_en, osc_en, osc_low_amp}, 8'b0011);
    chk("R7 pll down", {7'd0, pll_pd}, 8'd1);
    mode_req = 2'b00;
    cyc();
    wr(2'd0, 8'h00);
    mode_req = 2'b10;
    cyc();
    chk("R7 full stop", {6'd0, osc_en, osc_low_amp}, 8'd0);
    mode_req = 2'b00;
    cyc();
    chk("R7 resume", {5'd0, sys_clk_en, core_clk_en, osc_en}, 8'd7);
  endtask

  initial begin
    cyc(2);
    rst_n = 1;
    cyc();
    t_reset();
    t_auto_block();
    t_flag();
    t_wait_full();
    t_wait_partial();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule